// File: doc/BRIEF.md
# Depth-Banked Synchronous FIFO

This block is a single-clock first-in first-out queue whose storage is divided by depth into equal banks. Each bank is an inferred synchronous RAM that holds one contiguous slice of the logical address space. A flat write pointer addresses the queue, and its upper bits pick the bank. The read side uses the upper bits of the read pointer to choose the bank that holds the head entry. The bank outputs are then merged in two levels. Inside each group of banks, data passes through a chain of 2:1 multiplexers. The group results then feed a final selector.

The write side is a valid/ready stream. An entry is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the queue is full, and it does not depend on `in_valid`. The read side works in standard mode. A request on `out_req` is accepted when the queue is not empty. The entry then appears on `out_data` one clock later, with `out_valid` high for that one cycle. `out_data` keeps its value until the next accepted read. A request made while the queue is empty is dropped, so the consumer may keep `out_req` high and watch `out_valid`.

The full-size configuration is 16 banks of 512 entries each, 72 bits wide, giving 8192 entries. In that configuration the programmable-full threshold is 8001 and `wr_count` is 14 bits wide. The parameter defaults are a scaled-down instance of 16 banks of 64 entries. Every width follows from the parameters. The target clock is 156.25 MHz.

Top module: `banked_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `empty` is 1, `full`, `prog_full` and `out_valid` are 0, `wr_count` is 0 and `out_data` is all zeros.
- R2: Entries leave in the order they were accepted, with their data unchanged.
- R3: Read timing:
  - After an accepted read (`out_req` high while `empty` is low), `out_valid` is 1 and `out_data` holds the head entry in the next cycle.
  - In any cycle with no accepted read on the edge before it, `out_valid` is 0 and `out_data` is unchanged.
- R4: `full` and `in_ready` are both functions of the stored count. `full` is 1 and `in_ready` is 0 exactly when `wr_count` equals the total depth (`NUM_BANKS*BANK_DEPTH`).
- R5: A write offered while `full` is 1 is ignored. `wr_count` stays the same, and the ignored data never appears on `out_data`.
- R6: A read request while `empty` is 1 is ignored:
  - `out_valid` stays 0.
  - `out_data` and `wr_count` do not change.
- R7: `prog_full` is 1 exactly when `wr_count` is at least `PFULL`.
- R8: `wr_count` equals the number of stored entries. It rises by one after a lone accepted write and falls by one after a lone accepted read. It is unchanged when a write and a read are both accepted on the same edge.
- R9: Data stays intact when the pointers cross bank boundaries and wrap past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Write data offered |
| in_ready | output | 1 | Queue can take an entry (not full) |
| in_data | input | W | Write data |
| out_req | input | 1 | Read request |
| out_valid | output | 1 | `out_data` carries a newly read entry |
| out_data | output | W | Read data, held between reads |
| full | output | 1 | Queue holds total-depth entries |
| empty | output | 1 | Queue holds no entries |
| prog_full | output | 1 | Stored count is at least `PFULL` |
| wr_count | output | CW | Number of stored entries (CW = log2(depth)+1) |

## Verification
Two kinds of stimulus are used.

- **Directed sequences:**
  - A fill to full followed by a complete drain. This shows whether `full`, `prog_full` and the count thresholds switch at the right entry, and whether data is returned in order through every bank.
  - Requests on an empty queue and writes on a full queue. These separate dropped operations from accepted ones.
  - Simultaneous read and write at both extremes. These expose count errors on same-edge traffic.
- **Random traffic:** mixed random traffic with biased write and read rates. This moves the pointers through many wraps, which checks that bank selection and the registered read select keep the head entry aligned with the returned data.

// File: rtl/banked_fifo_pkg.sv
package banked_fifo_pkg;
  localparam int unsigned DEF_WIDTH      = 72;
  localparam int unsigned DEF_BANK_DEPTH = 64;
  localparam int unsigned DEF_NUM_BANKS  = 16;
  localparam int unsigned DEF_GROUP      = 4;
  localparam int unsigned DEF_PFULL      = 1000;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl #(
  parameter int unsigned AW    = 10,
  parameter int unsigned PFULL = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  logic        pop,
  output logic        wr_acc,
  output logic        rd_acc,
  output logic [AW:0] wptr,
  output logic [AW:0] rptr,
  output logic [AW:0] count,
  output logic        full,
  output logic        empty,
  output logic        prog_full
);
  localparam logic [AW:0] PF_LVL = PFULL[AW:0];

  assign empty  = (wptr == rptr);
  assign full   = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign wr_acc = push && !full;
  assign rd_acc = pop && !empty;
  assign count  = wptr - rptr;
  assign prog_full = (count >= PF_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_acc) wptr <= wptr + 1'b1;
      if (rd_acc) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/fifo_bank.sv
module fifo_bank #(
  parameter int unsigned W     = 72,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned OW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [OW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [OW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_out_tree.sv
module fifo_out_tree #(
  parameter int unsigned W     = 72,
  parameter int unsigned NB    = 16,
  parameter int unsigned GRP   = 4,
  localparam int unsigned BSW  = banked_fifo_pkg::bits_for(NB),
  localparam int unsigned NG   = NB / GRP,
  localparam int unsigned GSW  = $clog2(GRP)
) (
  input  logic [NB-1:0][W-1:0] bank_q,
  input  logic [BSW-1:0]       sel,
  output logic [W-1:0]         dout
);
  logic [W-1:0] grp_out [NG];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [W-1:0] chain [GRP];
    assign chain[0] = bank_q[g*GRP];
    for (genvar i = 1; i < GRP; i++) begin : g_stage
      assign chain[i] = ((32'(sel) & (GRP - 1)) == i) ? bank_q[g*GRP+i] : chain[i-1];
    end
    assign grp_out[g] = chain[GRP-1];
  end

  always_comb begin
    dout = grp_out[0];
    for (int g = 1; g < NG; g++) begin
      if ((32'(sel) >> GSW) == g) dout = grp_out[g];
    end
  end
endmodule

// File: rtl/banked_fifo.sv
module banked_fifo
  import banked_fifo_pkg::*;
#(
  parameter int unsigned W          = DEF_WIDTH,
  parameter int unsigned BANK_DEPTH = DEF_BANK_DEPTH,
  parameter int unsigned NUM_BANKS  = DEF_NUM_BANKS,
  parameter int unsigned GROUP      = DEF_GROUP,
  parameter int unsigned PFULL      = DEF_PFULL,
  localparam int unsigned DEPTH     = BANK_DEPTH * NUM_BANKS,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned CW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          out_req,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          full,
  output logic          empty,
  output logic          prog_full,
  output logic [CW-1:0] wr_count
);
  localparam int unsigned OW  = $clog2(BANK_DEPTH);
  localparam int unsigned BSW = bits_for(NUM_BANKS);

  logic          wr_acc, rd_acc;
  logic [AW:0]   wptr, rptr;
  logic [BSW-1:0] wbank, rbank, rsel_q;
  logic [NUM_BANKS-1:0][W-1:0] bank_q;

  fifo_ptr_ctrl #(.AW(AW), .PFULL(PFULL)) u_ctrl (
    .clk(clk), .rst(rst), .push(in_valid), .pop(out_req),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wptr(wptr), .rptr(rptr),
    .count(wr_count), .full(full), .empty(empty), .prog_full(prog_full)
  );

  assign in_ready = !full;
  assign wbank = BSW'(wptr[AW-1:0] >> OW);
  assign rbank = BSW'(rptr[AW-1:0] >> OW);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fifo_bank #(.W(W), .DEPTH(BANK_DEPTH)) u_bank (
      .clk(clk), .rst(rst),
      .we(wr_acc && (wbank == BSW'(b))),
      .waddr(wptr[OW-1:0]),
      .wdata(in_data),
      .re(rd_acc && (rbank == BSW'(b))),
      .raddr(rptr[OW-1:0]),
      .rdata(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= rd_acc;
      if (rd_acc) rsel_q <= rbank;
    end
  end

  fifo_out_tree #(.W(W), .NB(NUM_BANKS), .GRP(GROUP)) u_tree (
    .bank_q(bank_q), .sel(rsel_q), .dout(out_data)
  );
endmodule

// File: rtl/banked_fifo_chk.sv
module banked_fifo_chk #(
  parameter int unsigned W     = 72,
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned PFULL = 1000,
  parameter int unsigned CW    = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_req,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic          full,
  input logic          empty,
  input logic          prog_full,
  input logic [CW-1:0] wr_count
);
  a_r4_full_at_depth: assert property (@(posedge clk) disable iff (rst)
    full |-> (32'(wr_count) == DEPTH) && !in_ready);

  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  a_r6_empty_no_valid: assert property (@(posedge clk) disable iff (rst)
    (empty && out_req) |=> !out_valid);

  a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && $past(!rst)) |-> $stable(out_data));

  a_r7_pfull_level: assert property (@(posedge clk) disable iff (rst)
    prog_full == (32'(wr_count) >= PFULL));

  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (32'(wr_count) == 32'($past(wr_count))
      + 32'($past(in_valid && in_ready)) - 32'($past(out_req && !empty))));
endmodule

bind banked_fifo banked_fifo_chk #(.W(W), .DEPTH(DEPTH), .PFULL(PFULL), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_req(out_req), .out_valid(out_valid), .out_data(out_data),
  .full(full), .empty(empty), .prog_full(prog_full), .wr_count(wr_count)
);

// File: tb/banked_fifo_test.sv
module banked_fifo_test;
  localparam int W = 72, BD = 8, NB = 16, GRP = 4, PF = 100;
  localparam int DEPTH = BD * NB;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 0, rst = 1;
  logic in_valid = 0, out_req = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, full, empty, prog_full;
  logic [W-1:0] out_data;
  logic [CW-1:0] wr_count;

  banked_fifo #(.W(W), .BANK_DEPTH(BD), .NUM_BANKS(NB), .GROUP(GRP), .PFULL(PF)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_req(out_req), .out_valid(out_valid), .out_data(out_data),
    .full(full), .empty(empty), .prog_full(prog_full), .wr_count(wr_count)
  );

  always #5 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [W-1:0] model_q [$];
  logic [W-1:0] last_data = '0;
  logic exp_valid = 0;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rand_word();
    return W'({$urandom, $urandom, $urandom});
  endfunction

  task automatic check_flags();
    int n = model_q.size();
    check("R8 count", W'(wr_count), W'(n));
    check("R4 full", W'(full), W'(n == DEPTH));
    check("R4 in_ready", W'(in_ready), W'(n != DEPTH));
    check("R6 empty", W'(empty), W'(n == 0));
    check("R7 prog_full", W'(prog_full), W'(n >= PF));
  endtask

  task automatic cyc(input logic v, input logic [W-1:0] d, input logic r);
    bit wacc, racc;
    in_valid = v; in_data = d; out_req = r;
    @(posedge clk);
    wacc = v && (model_q.size() < DEPTH);
    racc = r && (model_q.size() > 0);
    if (racc) last_data = model_q.pop_front();
    if (wacc) model_q.push_back(d);
    exp_valid = racc;
    @(negedge clk);
    check("R3 out_valid", W'(out_valid), W'(exp_valid));
    check("R2 R3 R9 out_data", out_data, last_data);
    check_flags();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1;
    in_valid = 1; in_data = '1; out_req = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 empty", W'(empty), W'(1));
    check("R1 full", W'(full), W'(0));
    check("R1 prog_full", W'(prog_full), W'(0));
    check("R1 count", W'(wr_count), W'(0));
    check("R1 out_valid", W'(out_valid), W'(0));
    check("R1 out_data", out_data, '0);
    rst = 0;
    // R6 read while empty
    repeat (3) cyc(0, '0, 1);
    // R8 write and read both offered while empty: only write accepted
    cyc(1, rand_word(), 1);
    cyc(0, '0, 1);
    // fill to full, R4 R7 thresholds
    for (int i = 0; i < DEPTH; i++) cyc(1, rand_word(), 0);
    // R5 writes while full ignored
    repeat (4) cyc(1, {W{1'b1}}, 0);
    // R8 simultaneous while full: read accepted, write dropped
    cyc(1, {W{1'b1}}, 1);
    // R8 simultaneous with room: count stays
    repeat (5) cyc(1, rand_word(), 1);
    // drain entirely, R2 R9 across all banks
    for (int i = 0; i < DEPTH + 3; i++) cyc(0, '0, 1);
    // random traffic with phases of different bias, R9 wraps
    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 800; i++) begin
        int wb = (ph % 2 == 0) ? 70 : 35;
        cyc(($urandom % 100) < wb, rand_word(), ($urandom % 100) < 55);
      end
    end
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, '0, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule